// File: doc/BRIEF.md
# Programmable-Timing Serial Framing Engine

This block is the character engine of an asynchronous serial port. It contains a transmitter and a receiver that run independently and at the same time. A bit on the line does not come from a fixed oversampling divider. Each bit lasts a whole number of system clocks, taken from a 24-bit count that software normally sets to the clock frequency divided by the baud rate. The receiver samples each bit once, at a second programmed count within the bit, and does no majority voting.

The engine supports characters of five to eight data bits, an optional parity bit that can be even or odd, and one or two stop bits. A global enable works together with a separate enable for each direction. For transmit, the wrapper presents a byte with a valid strobe and watches a ready flag. For receive, the engine delivers each character as a one-cycle strobe with a data byte, a parity error flag and a stop error flag. Register access, FIFOs and interrupts belong to the wrapper around this block.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset the serial output is high, `rx_valid` is 0, and `tx_ready` is 1 when the global and transmit enables are set.
- R2: A transmitted frame begins with a low start bit, sends the data least significant bit first, and ends with high stop bits. Every bit holds on `txd` for exactly `cfg_bit_cnt` clocks, starting at the clock edge that accepts the byte.
- R3: `cfg_char_len` selects the number of data bits: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. `tx_data` bits above the selected length are not sent. In `rx_data`, the bits above the selected length are 0.
- R4: When `cfg_par_en` is 1, a parity bit follows the last data bit. It is computed over the configured data bits only. `cfg_par_even` = 1 selects even parity and 0 selects odd parity.
- R5: When `cfg_two_stop` is 1, the transmitter sends two stop bits. `tx_ready` returns to 1 exactly (1 + data bits + parity bit + stop bits) × `cfg_bit_cnt` clocks after the accepting edge.
- R6: The transmitter works only while both `cfg_en` and `cfg_tx_en` are 1. Otherwise `tx_ready` is 0 and `txd` stays high. The receiver works only while both `cfg_en` and `cfg_rx_en` are 1. Otherwise no `rx_valid` is produced.
- R7: The receiver finds a falling edge on the synchronised line and samples each bit when its bit counter equals `cfg_smp_cnt`. For each frame it raises `rx_valid` for exactly one cycle.
- R8: A received parity bit that does not match the configured parity sets `rx_par_err` together with `rx_valid`.
- R9: A stop bit sampled low sets `rx_stop_err`, and the data byte is still delivered with `rx_valid`.
- R10: If the line is high again when the start bit is sampled, the receiver returns to idle and produces no `rx_valid`.
- R11: A byte is accepted on a clock edge where both `tx_valid` and `tx_ready` are 1. `tx_ready` stays 0 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_en | input | 1 | Global enable |
| cfg_tx_en | input | 1 | Transmit direction enable |
| cfg_rx_en | input | 1 | Receive direction enable |
| cfg_char_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | Transmitter sends two stop bits |
| cfg_bit_cnt | input | 24 | Clocks per bit |
| cfg_smp_cnt | input | 24 | Counter value at which the receiver samples each bit |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle and enabled |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_par_err | output | 1 | Parity error of the delivered character |
| rx_stop_err | output | 1 | Stop error of the delivered character |

## Verification
A received character can be delivered in the same clock cycle that the transmitter accepts its next byte or moves from one bit to the next. The two paths share their configuration but nothing else. The bench provokes this overlap by looping `txd` back to `rxd` and sending frames with random lengths, parity and stop settings one after another. Both sides are then judged in every frame: each transmitted bit is sampled at the centre of its period against a bench-built frame, and the looped-back character and its flags are compared with the byte that was sent.

// File: rtl/uart_eng_pkg.sv
package uart_eng_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 12;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_t;

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // parity bit to send for the configured number of data bits
  function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                      input logic [1:0] code,
                                      input logic even);
    logic x;
    x = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(char_bits(code))) x = x ^ d[i];
    return even ? x : ~x;
  endfunction
endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end
  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/uart_bit_sync.sv
module uart_bit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] stg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b11;
    else        stg_q <= {stg_q[0], d_i};
  end
  assign q_o = stg_q[1];
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_eng_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [1:0]        code_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              two_stop_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  logic               busy_q, busy_n;
  logic [FRAME_W-1:0] frame_q, frame_n;
  logic [3:0]         left_q, left_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               txd_q, txd_n;
  logic [CNT_W:0]     cnt_inc;
  logic               bit_end, accept;
  logic [FRAME_W-1:0] built;
  logic [FRAME_W-1:0] dext;
  logic [3:0]         nbits;
  logic               pbit;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign bit_end = cnt_inc >= {1'b0, bit_cnt_i};
  assign accept  = run_i && !busy_q && valid_i;
  assign nbits   = char_bits(code_i);
  assign pbit    = parity_bit(data_i, code_i, par_even_i);
  assign dext    = {{(FRAME_W-DATA_W-1){1'b0}}, data_i, 1'b0};

  // frame with start at bit 0, idle-high padding above the last stop bit
  always_comb begin
    for (int k = 0; k < FRAME_W; k++) begin
      if (k == 0)                          built[k] = 1'b0;
      else if (k <= int'(nbits))           built[k] = dext[k];
      else if (par_en_i && k == int'(nbits) + 1) built[k] = pbit;
      else                                 built[k] = 1'b1;
    end
  end

  always_comb begin
    busy_n  = busy_q;
    frame_n = frame_q;
    left_n  = left_q;
    cnt_n   = cnt_q;
    txd_n   = txd_q;
    if (!run_i) begin
      busy_n = 1'b0;
      txd_n  = 1'b1;
      cnt_n  = '0;
    end else if (accept) begin
      busy_n  = 1'b1;
      txd_n   = built[0];
      frame_n = {1'b1, built[FRAME_W-1:1]};
      left_n  = 4'd2 + nbits + {3'b000, par_en_i} + {3'b000, two_stop_i};
      cnt_n   = '0;
    end else if (busy_q) begin
      if (bit_end) begin
        cnt_n = '0;
        if (left_q == 4'd1) begin
          busy_n = 1'b0;
          txd_n  = 1'b1;
        end else begin
          txd_n   = frame_q[0];
          frame_n = {1'b1, frame_q[FRAME_W-1:1]};
          left_n  = left_q - 4'd1;
        end
      end else begin
        cnt_n = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      busy_q  <= busy_n;
      frame_q <= frame_n;
      left_q  <= left_n;
      cnt_q   <= cnt_n;
      txd_q   <= txd_n;
    end
  end

  assign ready_o = run_i && !busy_q;
  assign txd_o   = txd_q;

  // R2: accepted byte puts the start bit on the line at the next edge
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !txd_o);
  // R6: a disabled transmitter leaves the line idle
  a_r6_tx_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> txd_o);
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_eng_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [1:0]        code_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [CNT_W-1:0]  smp_cnt_i,
  input  logic              rxs_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              stop_err_o
);
  rx_state_t         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [3:0]        idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              par_q, par_n;
  logic              prev_q;
  logic [DATA_W-1:0] data_q, data_n;
  logic              valid_q, valid_n, pe_q, pe_n, se_q, se_n;
  logic [CNT_W:0]    cnt_inc;
  logic              bit_end, smp;
  logic [3:0]        nbits;
  logic [DATA_W-1:0] aligned;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign bit_end = cnt_inc >= {1'b0, bit_cnt_i};
  assign smp     = cnt_q == smp_cnt_i;
  assign nbits   = char_bits(code_i);
  assign aligned = sh_q >> (4'd8 - nbits);

  always_comb begin
    st_n    = st_q;
    cnt_n   = bit_end ? '0 : cnt_inc[CNT_W-1:0];
    idx_n   = idx_q;
    sh_n    = sh_q;
    par_n   = par_q;
    data_n  = data_q;
    valid_n = 1'b0;
    pe_n    = pe_q;
    se_n    = se_q;
    if (!run_i) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          cnt_n = '0;
          if (prev_q && !rxs_i) st_n = RX_START;
        end
        RX_START: begin
          if (smp && rxs_i)  st_n = RX_IDLE;
          else if (bit_end) begin
            st_n  = RX_DATA;
            idx_n = '0;
          end
        end
        RX_DATA: begin
          if (smp) sh_n = {rxs_i, sh_q[DATA_W-1:1]};
          if (bit_end) begin
            if (idx_q == nbits - 4'd1) st_n = par_en_i ? RX_PAR : RX_STOP;
            else                       idx_n = idx_q + 4'd1;
          end
        end
        RX_PAR: begin
          if (smp)     par_n = rxs_i;
          if (bit_end) st_n  = RX_STOP;
        end
        RX_STOP: begin
          if (smp) begin
            st_n    = RX_IDLE;
            valid_n = 1'b1;
            data_n  = aligned;
            pe_n    = par_en_i && (par_q != parity_bit(aligned, code_i, par_even_i));
            se_n    = !rxs_i;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      prev_q  <= 1'b1;
      data_q  <= '0;
      valid_q <= 1'b0;
      pe_q    <= 1'b0;
      se_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      prev_q  <= rxs_i;
      data_q  <= data_n;
      valid_q <= valid_n;
      pe_q    <= pe_n;
      se_q    <= se_n;
    end
  end

  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign par_err_o  = pe_q;
  assign stop_err_o = se_q;

  // R7: one strobe per character
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R6: delivery only follows an enabled cycle
  a_r6_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(run_i));
  // R3: unused upper bits read as zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o >> nbits) == '0));
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_eng_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_tx_en,
  input  logic             cfg_rx_en,
  input  logic [1:0]       cfg_char_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic             cfg_two_stop,
  input  logic [CNT_W-1:0] cfg_bit_cnt,
  input  logic [CNT_W-1:0] cfg_smp_cnt,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_par_err,
  output logic             rx_stop_err
);
  logic rst_s_n, rxs;

  uart_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_s_n));
  uart_bit_sync u_rxs (.clk(clk), .rst_n(rst_s_n), .d_i(rxd), .q_o(rxs));

  uart_tx_path #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .run_i(cfg_en && cfg_tx_en),
    .code_i(cfg_char_len), .par_en_i(cfg_par_en), .par_even_i(cfg_par_even),
    .two_stop_i(cfg_two_stop), .bit_cnt_i(cfg_bit_cnt),
    .data_i(tx_data), .valid_i(tx_valid), .ready_o(tx_ready), .txd_o(txd));

  uart_rx_path #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .run_i(cfg_en && cfg_rx_en),
    .code_i(cfg_char_len), .par_en_i(cfg_par_en), .par_even_i(cfg_par_even),
    .bit_cnt_i(cfg_bit_cnt), .smp_cnt_i(cfg_smp_cnt), .rxs_i(rxs),
    .data_o(rx_data), .valid_o(rx_valid), .par_err_o(rx_par_err),
    .stop_err_o(rx_stop_err));
endmodule

// File: tb/test_uart_frame_engine.sv
`timescale 1ns/1ps
module test_uart_frame_engine;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en, cfg_tx_en, cfg_rx_en, cfg_par_en, cfg_par_even, cfg_two_stop;
  logic [1:0]  cfg_char_len;
  logic [23:0] cfg_bit_cnt, cfg_smp_cnt;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready, txd, rxd, rx_valid, rx_par_err, rx_stop_err;
  logic [7:0]  rx_data;
  logic        loop_mode, drv_rxd;

  int errors = 0, checks = 0, cycles = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last;
  logic       pe_last, se_last;

  always #10 clk = ~clk;
  assign rxd = loop_mode ? txd : drv_rxd;

  uart_frame_engine i_uart_frame_engine (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .cfg_char_len(cfg_char_len), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .cfg_bit_cnt(cfg_bit_cnt), .cfg_smp_cnt(cfg_smp_cnt), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
    .rx_stop_err(rx_stop_err));

  always @(posedge clk) begin
    #2;
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
      pe_last = rx_par_err;
      se_last = rx_stop_err;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] len_mask(input logic [1:0] code);
    return 8'hFF >> (3 - code);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] code, input logic ev);
    int ones;
    ones = $countones(d & len_mask(code));
    return ev ? ones[0] : ~ones[0];
  endfunction

  // expected line bits, bit 0 first; nb = number of bit periods
  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] code,
      input logic pe, input logic ev, input logic two, output int nb);
    logic [11:0] v;
    int n;
    n = 5 + int'(code);
    v = 12'hFFF;
    v[0] = 1'b0;
    for (int i = 0; i < n; i++) v[1+i] = d[i];
    if (pe) v[n+1] = exp_par(d, code, ev);
    nb = 2 + n + int'(pe) + int'(two);
    return v;
  endfunction

  // send one byte and sample every transmitted bit at its centre
  task automatic send_check(input logic [7:0] d);
    int nb, b, t;
    logic [11:0] f, cap, msk;
    logic rdy_mid, rdy_before;
    b = int'(cfg_bit_cnt);
    f = exp_frame(d, cfg_char_len, cfg_par_en, cfg_par_even, cfg_two_stop, nb);
    msk = 12'hFFF >> (12 - nb);
    cap = '0;
    rdy_mid = 1'b1; rdy_before = 1'b1;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (t = 0; t <= nb*b; t++) begin
      if (t > 0) @(negedge clk);
      if ((t % b) == b/2 && (t / b) < nb) cap[t/b] = txd;
      if (t == b + 1) rdy_mid = tx_ready;
      if (t == nb*b - 1) rdy_before = tx_ready;
    end
    chk(cap == (f & msk), "R2 R3 R4 R5 frame bits", int'(cap), int'(f & msk));
    chk(rdy_mid == 1'b0, "R11 ready low mid-frame", int'(rdy_mid), 0);
    chk(rdy_before == 1'b0 && tx_ready == 1'b1, "R5 frame length",
        int'({rdy_before, tx_ready}), 1);
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int nb);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      drv_rxd = bits[k];
      repeat (int'(cfg_bit_cnt) - 1) @(negedge clk);
    end
    @(negedge clk);
    drv_rxd = 1'b1;
    repeat (2 * int'(cfg_bit_cnt)) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] code, input logic pe, input logic ev,
                         input logic two, input int b, input int s);
    @(negedge clk);
    cfg_char_len = code; cfg_par_en = pe; cfg_par_even = ev;
    cfg_two_stop = two; cfg_bit_cnt = 24'(b); cfg_smp_cnt = 24'(s);
  endtask

  initial begin
    int c0, nb, b, s;
    logic [11:0] f;
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cfg_en = 1'b1; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
    cfg_char_len = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_two_stop = 1'b0;
    cfg_bit_cnt = 24'd16; cfg_smp_cnt = 24'd8;
    tx_data = 8'h00; tx_valid = 1'b0; loop_mode = 1'b0; drv_rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);

    // R6 transmit disabled: requests ignored, line stays high
    cfg_tx_en = 1'b0;
    tx_data = 8'h3C; tx_valid = 1'b1;
    begin
      logic seen_bad;
      seen_bad = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (tx_ready || !txd) seen_bad = 1'b1;
      end
      chk(!seen_bad, "R6 tx disabled ignores request", int'(seen_bad), 0);
    end
    tx_valid = 1'b0;
    cfg_tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(txd == 1'b1, "R6 no frame after re-enable", int'(txd), 1);

    // R6 receive disabled
    cfg_rx_en = 1'b0;
    c0 = rx_cnt;
    f = exp_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, nb);
    drive_rx(f, nb);
    chk(rx_cnt == c0, "R6 rx disabled no delivery", rx_cnt - c0, 0);
    cfg_rx_en = 1'b1;

    // R2 directed 8N1 frame
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 16, 8);
    send_check(8'hA5);
    // R3 R4 R5 five bits, even parity, two stops, upper bits ignored
    set_cfg(2'd0, 1'b1, 1'b1, 1'b1, 20, 10);
    send_check(8'hF7);
    // R4 odd parity, seven bits
    set_cfg(2'd2, 1'b1, 1'b0, 1'b0, 18, 9);
    send_check(8'hC3);

    // R8 parity error on received frame
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 16, 8);
    c0 = rx_cnt;
    f = exp_frame(8'h96, 2'd3, 1'b1, 1'b1, 1'b0, nb);
    f[9] = ~f[9];
    drive_rx(f, nb);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h96, "R8 data with bad parity",
        int'(rx_last), 'h96);
    chk(pe_last == 1'b1 && se_last == 1'b0, "R8 parity flag", int'({pe_last, se_last}), 2);

    // R9 stop error, data still delivered
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 16, 8);
    c0 = rx_cnt;
    f = exp_frame(8'h2B, 2'd1, 1'b0, 1'b0, 1'b0, nb);
    f[nb-1] = 1'b0;
    drive_rx(f, nb);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h2B, "R9 data with bad stop", int'(rx_last), 'h2B);
    chk(se_last == 1'b1 && pe_last == 1'b0, "R9 stop flag", int'({pe_last, se_last}), 1);

    // R10 short low pulse is a glitch
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 16, 8);
    c0 = rx_cnt;
    @(negedge clk); drv_rxd = 1'b0;
    repeat (2) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (48) @(negedge clk);
    chk(rx_cnt == c0, "R10 glitch ignored", rx_cnt - c0, 0);
    f = exp_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, nb);
    drive_rx(f, nb);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h81, "R10 R7 receive after glitch",
        int'(rx_last), 'h81);

    // R7 R3 R4 random loopback with overlapping tx and rx activity
    loop_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      b = 16 + int'($urandom % 25);
      s = 7 + int'($urandom % (b - 11));
      set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), b, s);
      d = 8'($urandom);
      c0 = rx_cnt;
      send_check(d);
      repeat (2) @(negedge clk);
      chk(rx_cnt == c0 + 1, "R7 one delivery per frame", rx_cnt - c0, 1);
      chk(rx_last == (d & len_mask(cfg_char_len)) && !pe_last && !se_last,
          "R3 R4 R7 loopback data", int'({pe_last, se_last, rx_last}),
          int'(d & len_mask(cfg_char_len)));
    end
    summary();
  end
endmodule